// File: doc/BRIEF.md
# Watermarked Stream Buffer with Integrity Flags

This block sits between one acquisition module's packetizer and the aggregation fabric of a multi-module data plane. Sample words enter from the source and leave toward the aggregator through a valid/ready handshake, in arrival order. Each stored word is tagged with a sequence number and a gap bit, so a receiver can tell when any word was lost upstream of it.

Occupancy is compared against three programmable thresholds, which are reported as level flags before the buffer is full. A throttle output with hysteresis asks the source to pause. If the source keeps writing into a full buffer, the word is refused. The stored contents stay untouched, a drop counter is incremented, a sticky drop flag is raised and the next accepted word is marked with the gap bit. Saturating counters accumulate link CRC-error and retry pulses that come in from outside. A peak-occupancy register keeps the highest fill level reached. One clear strobe resets the counters, the flag and the peak.

Top module: `stream_guard_buf`

## Requirements
- R1: After reset, out_valid, throttle, out_gap, drop_flag, peak_fill and all three counters are 0, and all three level flags show an empty buffer.
- R2: Accepted words leave in arrival order. out_valid is 1 exactly when the buffer holds at least one word, and a word is removed in a cycle where out_valid and out_ready are both 1.
- R3: wm_low, wm_mid and wm_high are each 1 exactly when the present occupancy is greater than or equal to thr_low, thr_mid or thr_high respectively.
- R4: throttle becomes 1 on the clock edge after one where occupancy is at least thr_high. It becomes 0 on the clock edge after one where occupancy is below thr_mid. Between those conditions it keeps its value.
- R5: out_seq of each word is the number of words accepted before it since reset, modulo 2^SEQ_W, starting at 0.
- R6: A word offered while the buffer holds DEPTH words and no word leaves in that cycle is discarded. Stored words and occupancy are unchanged, drop_cnt increments and drop_flag is set. If a word leaves in that same cycle, the offered word is accepted.
- R7: out_gap is 1 on the first word accepted after one or more discards, and 0 on every other word.
- R8: crc_err_cnt counts cycles with crc_err_pulse high and saturates at 2^CNT_W-1.
- R9: retry_cnt counts cycles with retry_pulse high and saturates at 2^CNT_W-1. drop_cnt saturates at the same value.
- R10: A cycle with clr_stats high sets all three counters and drop_flag to 0, and sets peak_fill to the occupancy after that edge. The clear takes priority over an increment in the same cycle. drop_flag otherwise stays at 1 once set.
- R11: peak_fill is the highest occupancy held after any clock edge since reset or the last clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_valid | input | 1 | Source offers a word this cycle |
| src_data | input | DATA_W | Sample word from the source |
| throttle | output | 1 | Backpressure request toward the source |
| out_valid | output | 1 | A word is presented to the aggregator |
| out_ready | input | 1 | Aggregator takes the presented word |
| out_data | output | DATA_W | Presented sample word |
| out_seq | output | SEQ_W | Sequence number of the presented word |
| out_gap | output | 1 | Presented word follows one or more discards |
| thr_low | input | OCC_W | Low fill threshold |
| thr_mid | input | OCC_W | Mid fill threshold (throttle release) |
| thr_high | input | OCC_W | High fill threshold (throttle set) |
| wm_low | output | 1 | Occupancy at or above thr_low |
| wm_mid | output | 1 | Occupancy at or above thr_mid |
| wm_high | output | 1 | Occupancy at or above thr_high |
| peak_fill | output | OCC_W | Highest occupancy since reset or clear |
| crc_err_pulse | input | 1 | One link CRC error event |
| retry_pulse | input | 1 | One link retry event |
| clr_stats | input | 1 | Clear counters, drop flag and peak |
| crc_err_cnt | output | CNT_W | Saturating CRC-error count |
| retry_cnt | output | CNT_W | Saturating retry count |
| drop_cnt | output | CNT_W | Saturating discarded-word count |
| drop_flag | output | 1 | Sticky: at least one word discarded |

## Verification
In one traffic pattern the source obeys throttle and the aggregator stalls at random. In that pattern the buffer should never overflow, so it shows the hysteresis band and the in-order sequence numbering with no gap bits. In a second pattern the source ignores throttle while the aggregator stalls, and the thresholds are made tight. Here discards happen, including writes into a full buffer during a cycle that also pops. This pattern separates a discard from an accepted write through the drop counter, the gap bit on the next word and the unchanged stored contents. Directed runs fill the buffer with output stalled, drive more than 2^CNT_W pulses to reach saturation, and raise clear together with a pulse to show that clear takes priority.

// File: rtl/sgb_pkg.sv
`timescale 1ns/1ps
package sgb_pkg;

  typedef enum logic {THR_OPEN = 1'b0, THR_HOLD = 1'b1} thr_state_e;

  // level flag: occupancy at or above a threshold
  function automatic logic lvl_reached(int unsigned occ, int unsigned thr);
    return occ >= thr;
  endfunction

  // throttle hysteresis: set at/above high, release below mid, else hold
  function automatic thr_state_e thr_next(thr_state_e cur, int unsigned occ,
                                          int unsigned hi, int unsigned mid);
    if (occ >= hi) return THR_HOLD;
    if (occ < mid) return THR_OPEN;
    return cur;
  endfunction

  // peak tracker: restart on clear, else keep the maximum
  function automatic int unsigned peak_next(int unsigned cur, int unsigned occ, logic clr);
    if (clr) return occ;
    return (occ > cur) ? occ : cur;
  endfunction

endpackage

// File: rtl/sgb_fifo_store.sv
`timescale 1ns/1ps
module sgb_fifo_store #(
  parameter int W     = 33,
  parameter int DEPTH = 16,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [W-1:0]     wdata,
  output logic [W-1:0]     rdata,
  output logic [OCC_W-1:0] count,
  output logic [OCC_W-1:0] count_nxt,
  output logic             full,
  output logic             empty
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  function automatic logic [AW-1:0] ptr_adv(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full      = (count == OCC_W'(DEPTH));
  assign empty     = (count == '0);
  assign rdata     = mem[rd_ptr];
  assign count_nxt = count + OCC_W'(push) - OCC_W'(pop);

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= ptr_adv(wr_ptr);
      if (pop)  rd_ptr <= ptr_adv(rd_ptr);
      count <= count_nxt;
    end
  end

endmodule

// File: rtl/sgb_level_mon.sv
`timescale 1ns/1ps
module sgb_level_mon
  import sgb_pkg::*;
#(
  parameter int OCC_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [OCC_W-1:0] occ,
  input  logic [OCC_W-1:0] occ_nxt,
  input  logic [OCC_W-1:0] thr_low,
  input  logic [OCC_W-1:0] thr_mid,
  input  logic [OCC_W-1:0] thr_high,
  output logic             wm_low,
  output logic             wm_mid,
  output logic             wm_high,
  output logic             throttle,
  output logic [OCC_W-1:0] peak
);

  thr_state_e thr_q;

  assign wm_low   = lvl_reached(32'(occ), 32'(thr_low));
  assign wm_mid   = lvl_reached(32'(occ), 32'(thr_mid));
  assign wm_high  = lvl_reached(32'(occ), 32'(thr_high));
  assign throttle = (thr_q == THR_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q <= THR_OPEN;
      peak  <= '0;
    end else begin
      thr_q <= thr_next(thr_q, 32'(occ), 32'(thr_high), 32'(thr_mid));
      peak  <= OCC_W'(peak_next(32'(peak), 32'(occ_nxt), clr));
    end
  end

endmodule

// File: rtl/sgb_sat_ctr.sv
`timescale 1ns/1ps
module sgb_sat_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);

  function automatic logic [W-1:0] sat_step(logic [W-1:0] v);
    return (v == '1) ? v : v + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= sat_step(cnt);
  end

endmodule

// File: rtl/stream_guard_buf.sv
`timescale 1ns/1ps
module stream_guard_buf #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  parameter int SEQ_W  = 16,
  parameter int CNT_W  = 8,
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_valid,
  input  logic [DATA_W-1:0] src_data,
  output logic              throttle,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [SEQ_W-1:0]  out_seq,
  output logic              out_gap,
  input  logic [OCC_W-1:0]  thr_low,
  input  logic [OCC_W-1:0]  thr_mid,
  input  logic [OCC_W-1:0]  thr_high,
  output logic              wm_low,
  output logic              wm_mid,
  output logic              wm_high,
  output logic [OCC_W-1:0]  peak_fill,
  input  logic              crc_err_pulse,
  input  logic              retry_pulse,
  input  logic              clr_stats,
  output logic [CNT_W-1:0]  crc_err_cnt,
  output logic [CNT_W-1:0]  retry_cnt,
  output logic [CNT_W-1:0]  drop_cnt,
  output logic              drop_flag
);

  localparam int ENT_W = 1 + SEQ_W + DATA_W;
  localparam int NSTAT = 3;
  localparam int ST_CRC = 0, ST_RETRY = 1, ST_DROP = 2;

  // named internal events (observed by the bound checker)
  logic              push_evt, pop_evt, drop_evt;
  logic              buf_full, buf_empty;
  logic [OCC_W-1:0]  occ, occ_nxt;
  logic [SEQ_W-1:0]  seq_ctr;
  logic              gap_pend;
  logic [ENT_W-1:0]  wr_ent, rd_ent;

  assign pop_evt  = out_valid & out_ready;
  assign push_evt = src_valid & (~buf_full | pop_evt);
  assign drop_evt = src_valid & buf_full & ~pop_evt;
  assign wr_ent   = {gap_pend, seq_ctr, src_data};

  sgb_fifo_store #(.W(ENT_W), .DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push_evt),
    .pop       (pop_evt),
    .wdata     (wr_ent),
    .rdata     (rd_ent),
    .count     (occ),
    .count_nxt (occ_nxt),
    .full      (buf_full),
    .empty     (buf_empty)
  );

  assign out_valid = ~buf_empty;
  assign out_data  = rd_ent[DATA_W-1:0];
  assign out_seq   = rd_ent[DATA_W +: SEQ_W];
  assign out_gap   = out_valid & rd_ent[ENT_W-1];

  sgb_level_mon #(.OCC_W(OCC_W)) u_level (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr_stats),
    .occ      (occ),
    .occ_nxt  (occ_nxt),
    .thr_low  (thr_low),
    .thr_mid  (thr_mid),
    .thr_high (thr_high),
    .wm_low   (wm_low),
    .wm_mid   (wm_mid),
    .wm_high  (wm_high),
    .throttle (throttle),
    .peak     (peak_fill)
  );

  // sequence tagging and gap marking
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_ctr  <= '0;
      gap_pend <= 1'b0;
    end else begin
      if (push_evt) begin
        seq_ctr  <= seq_ctr + 1'b1;
        gap_pend <= 1'b0;
      end else if (drop_evt) begin
        gap_pend <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         drop_flag <= 1'b0;
    else if (clr_stats) drop_flag <= 1'b0;
    else if (drop_evt)  drop_flag <= 1'b1;
  end

  // integrity counters
  logic [NSTAT-1:0] stat_inc;
  logic [CNT_W-1:0] stat_cnt [NSTAT];

  assign stat_inc[ST_CRC]   = crc_err_pulse;
  assign stat_inc[ST_RETRY] = retry_pulse;
  assign stat_inc[ST_DROP]  = drop_evt;

  for (genvar g = 0; g < NSTAT; g++) begin : g_stat
    sgb_sat_ctr #(.W(CNT_W)) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr_stats),
      .inc   (stat_inc[g]),
      .cnt   (stat_cnt[g])
    );
  end

  assign crc_err_cnt = stat_cnt[ST_CRC];
  assign retry_cnt   = stat_cnt[ST_RETRY];
  assign drop_cnt    = stat_cnt[ST_DROP];

endmodule

// File: rtl/sgb_checks.sv
`timescale 1ns/1ps
module sgb_checks #(
  parameter int DEPTH = 16,
  parameter int SEQ_W = 16,
  parameter int CNT_W = 8,
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr,
  input logic             push_evt,
  input logic             pop_evt,
  input logic             drop_evt,
  input logic [OCC_W-1:0] occ,
  input logic [SEQ_W-1:0] seq_ctr,
  input logic             throttle,
  input logic [OCC_W-1:0] thr_mid,
  input logic [OCC_W-1:0] thr_high,
  input logic             drop_flag,
  input logic [CNT_W-1:0] crc_cnt,
  input logic [CNT_W-1:0] retry_cnt,
  input logic [OCC_W-1:0] peak
);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) occ <= OCC_W'(DEPTH)); // R6
  AST_OUT_ORDER_POP: assert property (@(posedge clk) disable iff (!rst_n) pop_evt |-> occ != '0); // R2
  AST_THR_SET: assert property (@(posedge clk) disable iff (!rst_n) (occ >= thr_high) |=> throttle); // R4
  AST_THR_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) (occ < thr_mid && occ < thr_high) |=> !throttle); // R4
  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n) push_evt |=> seq_ctr == $past(seq_ctr) + 1'b1); // R5
  AST_SEQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !push_evt |=> $stable(seq_ctr)); // R5
  AST_DROP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n) drop_evt |=> occ == $past(occ)); // R6
  AST_DROP_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (drop_flag && !clr) |=> drop_flag); // R10
  AST_CRC_SAT: assert property (@(posedge clk) disable iff (!rst_n) (crc_cnt == '1 && !clr) |=> crc_cnt == '1); // R8
  AST_RETRY_SAT: assert property (@(posedge clk) disable iff (!rst_n) (retry_cnt == '1 && !clr) |=> retry_cnt == '1); // R9
  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n) clr |=> (crc_cnt == '0 && retry_cnt == '0 && !drop_flag)); // R10
  AST_PEAK_MONO: assert property (@(posedge clk) disable iff (!rst_n) !clr |=> peak >= $past(peak)); // R11
  AST_PEAK_COVERS: assert property (@(posedge clk) disable iff (!rst_n) peak >= occ); // R11

endmodule

bind stream_guard_buf sgb_checks #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .clr       (clr_stats),
  .push_evt  (push_evt),
  .pop_evt   (pop_evt),
  .drop_evt  (drop_evt),
  .occ       (occ),
  .seq_ctr   (seq_ctr),
  .throttle  (throttle),
  .thr_mid   (thr_mid),
  .thr_high  (thr_high),
  .drop_flag (drop_flag),
  .crc_cnt   (crc_err_cnt),
  .retry_cnt (retry_cnt),
  .peak      (peak_fill)
);

// File: tb/stream_guard_buf_tb.sv
`timescale 1ns/1ps
module stream_guard_buf_tb;

  localparam int DATA_W = 16;
  localparam int DEPTH  = 16;
  localparam int SEQ_W  = 16;
  localparam int CNT_W  = 8;
  localparam int OCC_W  = $clog2(DEPTH + 1);
  localparam int CMAX   = (1 << CNT_W) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic src_valid = 0, out_ready = 0, crc_p = 0, retry_p = 0, clr = 0;
  logic [DATA_W-1:0] src_data = '0;
  logic [OCC_W-1:0] thr_low = 4, thr_mid = 8, thr_high = 12;
  logic throttle, out_valid, out_gap, wm_low, wm_mid, wm_high, drop_flag;
  logic [DATA_W-1:0] out_data;
  logic [SEQ_W-1:0] out_seq;
  logic [OCC_W-1:0] peak_fill;
  logic [CNT_W-1:0] crc_cnt, retry_cnt, drop_cnt;

  always #2 clk = ~clk;

  stream_guard_buf #(.DATA_W(DATA_W), .DEPTH(DEPTH), .SEQ_W(SEQ_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_data(src_data),
    .throttle(throttle), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_seq(out_seq), .out_gap(out_gap),
    .thr_low(thr_low), .thr_mid(thr_mid), .thr_high(thr_high),
    .wm_low(wm_low), .wm_mid(wm_mid), .wm_high(wm_high), .peak_fill(peak_fill),
    .crc_err_pulse(crc_p), .retry_pulse(retry_p), .clr_stats(clr),
    .crc_err_cnt(crc_cnt), .retry_cnt(retry_cnt), .drop_cnt(drop_cnt), .drop_flag(drop_flag)
  );

  int total = 0, bad = 0;
  bit done = 0;

  // reference model state
  logic [DATA_W+SEQ_W:0] mq[$];
  int m_seq = 0, m_crc = 0, m_retry = 0, m_drop = 0, m_peak = 0;
  bit m_gap = 0, m_flag = 0, m_thr = 0;

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int sat(int v);
    return (v >= CMAX) ? CMAX : v + 1;
  endfunction

  // model of one clock edge, from the requirements
  task automatic model_edge();
    int n = mq.size();
    bit pop = (n > 0) && out_ready;
    bit full = (n == DEPTH);
    bit push = src_valid && (!full || pop);
    bit drop = src_valid && full && !pop;
    if (n >= int'(thr_high)) m_thr = 1;         // R4
    else if (n < int'(thr_mid)) m_thr = 0;
    if (pop) void'(mq.pop_front());
    if (push) begin
      mq.push_back({m_gap, SEQ_W'(m_seq), src_data});
      m_seq = (m_seq + 1) % (1 << SEQ_W);
      m_gap = 0;
    end else if (drop) m_gap = 1;
    if (clr) begin
      m_crc = 0; m_retry = 0; m_drop = 0; m_flag = 0; m_peak = mq.size();
    end else begin
      if (crc_p) m_crc = sat(m_crc);
      if (retry_p) m_retry = sat(m_retry);
      if (drop) begin m_drop = sat(m_drop); m_flag = 1; end
      if (mq.size() > m_peak) m_peak = mq.size();
    end
  endtask

  task automatic compare_all();
    int n = mq.size();
    check("R2 out_valid", int'(out_valid), int'(n > 0));
    if (n > 0) begin
      check("R2 out_data", int'(out_data), int'(mq[0][DATA_W-1:0]));
      check("R5 out_seq", int'(out_seq), int'(mq[0][DATA_W +: SEQ_W]));
      check("R7 out_gap", int'(out_gap), int'(mq[0][DATA_W+SEQ_W]));
    end
    check("R3 wm_low", int'(wm_low), int'(n >= int'(thr_low)));
    check("R3 wm_mid", int'(wm_mid), int'(n >= int'(thr_mid)));
    check("R3 wm_high", int'(wm_high), int'(n >= int'(thr_high)));
    check("R4 throttle", int'(throttle), int'(m_thr));
    check("R8 crc_err_cnt", int'(crc_cnt), m_crc);
    check("R9 retry_cnt", int'(retry_cnt), m_retry);
    check("R6 drop_cnt", int'(drop_cnt), m_drop);
    check("R10 drop_flag", int'(drop_flag), int'(m_flag));
    check("R11 peak_fill", int'(peak_fill), m_peak);
  endtask

  // called at a falling edge with inputs set
  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
  endtask

  task automatic drive(bit v, bit r, bit c, bit t, bit k);
    src_valid = v; src_data = DATA_W'($urandom); out_ready = r;
    crc_p = c; retry_p = t; clr = k;
    step();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 out_valid", int'(out_valid), 0);
    check("R1 throttle", int'(throttle), 0);
    check("R1 drop_flag", int'(drop_flag), 0);
    check("R1 peak_fill", int'(peak_fill), 0);
    check("R1 counters", int'(crc_cnt) + int'(retry_cnt) + int'(drop_cnt), 0);
    check("R1 wm_low", int'(wm_low), 0);

    // obedient source, random stalls (R2 R3 R4 R5)
    for (int i = 0; i < 2000; i++)
      drive(($urandom % 2 == 1) && !throttle, ($urandom % 4) != 0,
            ($urandom % 8) == 0, ($urandom % 16) == 0, 1'b0);

    // drain, then fill with output stalled and overrun (R6 R7)
    for (int i = 0; i < DEPTH + 4; i++) drive(1'b0, 1'b1, 0, 0, 0);
    for (int i = 0; i < DEPTH + 5; i++) drive(1'b1, 1'b0, 0, 0, 0);
    check("R6 drop_cnt after overrun", int'(drop_cnt), 5);
    // full buffer, write with simultaneous pop is accepted
    drive(1'b1, 1'b1, 0, 0, 0);
    for (int i = 0; i < DEPTH + 2; i++) drive(1'b0, 1'b1, 0, 0, 0);

    // saturation (R8 R9)
    for (int i = 0; i < CMAX + 40; i++) drive(1'b0, 1'b1, 1'b1, i % 2 == 0, 0);
    check("R8 crc saturated", int'(crc_cnt), CMAX);
    // clear beats same-cycle pulse (R10)
    drive(1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
    check("R10 crc after clear", int'(crc_cnt), 0);
    check("R10 peak after clear", int'(peak_fill), 1);

    // tight thresholds, source ignoring throttle (R4 R6 R7 R11)
    thr_low = 1; thr_mid = 2; thr_high = 3;
    for (int i = 0; i < 1500; i++)
      drive(($urandom % 4) != 0, ($urandom % 3) == 0,
            ($urandom % 8) == 0, 1'b0, ($urandom % 200) == 0);
    thr_low = 5; thr_mid = 10; thr_high = 15;
    for (int i = 0; i < 1500; i++)
      drive(($urandom % 3) != 0, ($urandom % 2) == 0, 1'b0, 1'b1, 1'b0);
    finish_run();
  end

endmodule